// File: doc/BRIEF.md
# DS3 Receive Overhead Alarm Monitor

This block sits behind a DS3 frame aligner that has already pulled the overhead bits out of each received M-frame. For every accepted frame it takes the pair of X-bits, the three far-end block error (FEBE) bits, the application identification channel (AIC) bit and an idle-frame flag. From these it tracks the far-end receive failure (yellow alarm) state, the framing format signalled by the AIC bit, and a debounced idle condition. It also counts frames that report far-end block errors.

Each change of alarm, AIC or idle state raises a sticky interrupt flag. A read clears the flag. Each flag can be enabled individually onto a single interrupt line. A byte-wide register port gives a microprocessor access to the status, the interrupt flags, the enables and the 16-bit error counter.

The overhead input is a valid/ready stream. The block never applies back-pressure: `oh_ready` is always 1, and every cycle with `oh_valid` high carries one frame. An upstream source may therefore present a new frame on every clock.

Top module: `ds3_rx_oh_monitor`

## Requirements
- R1: After reset, registers 0x11, 0x12, 0x13, 0x58 and 0x59 read 0, `irq` is low and `oh_ready` is high.
- R2: A frame with X-bits 2'b00 sets the alarm state, which appears at bit 4 of register 0x11. A frame with X-bits 2'b11 clears it. A frame with X-bits 2'b01 or 2'b10 leaves it unchanged.
- R3: Every change of the alarm state sets bit 3 of register 0x13.
- R4: Bits 2:0 of register 0x11 hold the FEBE field of the last frame, and bit 3 holds its AIC bit. A change of the AIC bit sets bit 2 of register 0x13. Bits 7:5 of register 0x11 read 0.
- R5: A frame whose FEBE field is not 3'b111 increments the 16-bit error counter. A FEBE field of 3'b111 leaves the counter unchanged. The counter stops at 16'hFFFF.
- R6: Reading 0x58 returns the counter's high byte and captures its low byte. Reading 0x59 returns the captured byte and clears the counter. An error frame in the same cycle as that clear leaves the counter at 1.
- R7: An up/down counter rises on idle frames and falls on non-idle frames, saturating at 0 and at IDLE_THR (default 15). Reaching IDLE_THR declares idle, and returning to 0 ends it. Each of these two transitions sets bit 4 of register 0x13.
- R8: A read of 0x13 returns the flags and then clears them. A flag set in the same cycle as that read stays set. Bits 7, 6, 5, 1 and 0 of 0x13 (CP-bit, LOS, AIS, OOF, P-bit positions) always read 0.
- R9: Register 0x12 is a read/write enable mask. `irq` is high exactly when some flag in 0x13 is set together with its enable bit.
- R10: While `oh_valid` is low, the overhead inputs change no status, flag or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oh_valid | input | 1 | Overhead of one M-frame is present |
| oh_ready | output | 1 | Always 1; the block accepts every frame |
| oh_xbits | input | 2 | The two X-bits of the frame |
| oh_febe | input | 3 | The three FEBE bits of the frame |
| oh_aic | input | 1 | AIC bit (1 = C-bit parity, 0 = M13) |
| oh_idle | input | 1 | Frame carries the idle pattern |
| cpu_addr | input | 8 | Register address |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle of `cpu_rd` |
| irq | output | 1 | Enabled interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first is a clear-on-read of 0x13 against a frame that changes the alarm state. The second is the counter clear on a read of 0x59 against an error frame. The bench provokes each collision by driving a frame and a read on the same clock. For the first, the read must return the old flags, and the new alarm flag must survive into the next read. For the second, the next 0x58/0x59 pair must read exactly 1, so the increment was not lost.

// File: rtl/ds3mon_pkg.sv
package ds3mon_pkg;
  localparam int FEBE_CNT_W = 16;
  localparam int BYTE_W     = 8;

  localparam logic [7:0] ADDR_STAT = 8'h11;
  localparam logic [7:0] ADDR_MASK = 8'h12;
  localparam logic [7:0] ADDR_INT  = 8'h13;
  localparam logic [7:0] ADDR_CNTH = 8'h58;
  localparam logic [7:0] ADDR_CNTL = 8'h59;

  // flag positions in the interrupt register, fixed by software decode
  localparam int INT_CP   = 7;
  localparam int INT_LOS  = 6;
  localparam int INT_AIS  = 5;
  localparam int INT_IDLE = 4;
  localparam int INT_FERF = 3;
  localparam int INT_AIC  = 2;
  localparam int INT_OOF  = 1;
  localparam int INT_PBIT = 0;

  localparam logic [7:0] INT_LIVE = 8'b0001_1100;
endpackage

// File: rtl/ds3mon_status.sv
module ds3mon_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fr_vld,
  input  logic [1:0] fr_x,
  input  logic [2:0] fr_febe,
  input  logic       fr_aic,
  output logic       ferf,
  output logic       aic,
  output logic [2:0] febe_last,
  output logic       ferf_chg,
  output logic       aic_chg
);
  logic x_low, x_high;
  assign x_low  = (fr_x == 2'b00);
  assign x_high = (fr_x == 2'b11);

  assign ferf_chg = fr_vld && ((x_low && !ferf) || (x_high && ferf));
  assign aic_chg  = fr_vld && (fr_aic != aic);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ferf      <= 1'b0;
      aic       <= 1'b0;
      febe_last <= '0;
    end else if (fr_vld) begin
      if (x_low)       ferf <= 1'b1;
      else if (x_high) ferf <= 1'b0;
      aic       <= fr_aic;
      febe_last <= fr_febe;
    end
  end

  // R2
  ferf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_vld && fr_x == 2'b00) |=> ferf);
  // R2
  ferf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_vld && (fr_x == 2'b01 || fr_x == 2'b10)) |=> $stable(ferf));
  // R10
  idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_vld |=> ($stable(ferf) && $stable(aic) && $stable(febe_last)));
endmodule

// File: rtl/ds3mon_idle.sv
module ds3mon_idle #(
  parameter int IDLE_THR = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fr_vld,
  input  logic fr_idle,
  output logic idle_st,
  output logic idle_chg
);
  localparam int CW = $clog2(IDLE_THR + 1);
  localparam logic [CW-1:0] TOP = CW'(IDLE_THR);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (fr_vld) begin
      if (fr_idle && cnt != TOP)    cnt_nxt = cnt + 1'b1;
      else if (!fr_idle && cnt != '0) cnt_nxt = cnt - 1'b1;
    end
  end

  assign idle_chg = fr_vld && ((cnt_nxt == TOP && !idle_st) ||
                               (cnt_nxt == '0 && idle_st));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      idle_st <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (idle_chg) idle_st <= !idle_st;
    end
  end

  // R7
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_st) |-> (cnt == TOP));
  // R7
  idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_st) |-> (cnt == '0));
  // R7
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
endmodule

// File: rtl/ds3mon_febe_cnt.sv
module ds3mon_febe_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         hi_rd,
  input  logic         lo_rd,
  output logic [W-1:0] cnt,
  output logic [7:0]   snap_lo
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      snap_lo <= '0;
    end else begin
      if (lo_rd)                  cnt <= inc ? W'(1) : '0;
      else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
      if (hi_rd) snap_lo <= cnt[7:0];
    end
  end

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !lo_rd) |=> (cnt == MAXV));
  // R6
  clr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && inc) |=> (cnt == W'(1)));
  // R5
  no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !lo_rd) |=> $stable(cnt));
endmodule

// File: rtl/ds3_rx_oh_monitor.sv
module ds3_rx_oh_monitor
  import ds3mon_pkg::*;
#(
  parameter int IDLE_THR = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oh_valid,
  output logic       oh_ready,
  input  logic [1:0] oh_xbits,
  input  logic [2:0] oh_febe,
  input  logic       oh_aic,
  input  logic       oh_idle,
  input  logic [7:0] cpu_addr,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       irq
);
  logic       fr_vld;
  logic       ferf, aic, ferf_chg, aic_chg, idle_st, idle_chg;
  logic [2:0] febe_last;
  logic [FEBE_CNT_W-1:0] ecnt;
  logic [7:0] snap_lo;
  logic [7:0] mask_q, int_q, int_set;
  logic       rd_int, rd_hi, rd_lo;

  assign oh_ready = 1'b1;
  assign fr_vld   = oh_valid && oh_ready;

  assign rd_int = cpu_rd && (cpu_addr == ADDR_INT);
  assign rd_hi  = cpu_rd && (cpu_addr == ADDR_CNTH);
  assign rd_lo  = cpu_rd && (cpu_addr == ADDR_CNTL);

  ds3mon_status u_stat (
    .clk(clk), .rst_n(rst_n), .fr_vld(fr_vld), .fr_x(oh_xbits),
    .fr_febe(oh_febe), .fr_aic(oh_aic), .ferf(ferf), .aic(aic),
    .febe_last(febe_last), .ferf_chg(ferf_chg), .aic_chg(aic_chg)
  );

  ds3mon_idle #(.IDLE_THR(IDLE_THR)) u_idle (
    .clk(clk), .rst_n(rst_n), .fr_vld(fr_vld), .fr_idle(oh_idle),
    .idle_st(idle_st), .idle_chg(idle_chg)
  );

  ds3mon_febe_cnt #(.W(FEBE_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(fr_vld && oh_febe != 3'b111),
    .hi_rd(rd_hi), .lo_rd(rd_lo), .cnt(ecnt), .snap_lo(snap_lo)
  );

  always_comb begin
    int_set           = '0;
    int_set[INT_IDLE] = idle_chg;
    int_set[INT_FERF] = ferf_chg;
    int_set[INT_AIC]  = aic_chg;
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : g_flag
    if (INT_LIVE[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)          int_q[i] <= 1'b0;
        else if (int_set[i]) int_q[i] <= 1'b1;
        else if (rd_int)     int_q[i] <= 1'b0;
      end
    end else begin : g_tied
      assign int_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              mask_q <= '0;
    else if (cpu_wr && cpu_addr == ADDR_MASK) mask_q <= cpu_wdata;
  end

  assign irq = |(int_q & mask_q);

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      unique case (cpu_addr)
        ADDR_STAT: cpu_rdata = {3'b000, ferf, aic, febe_last};
        ADDR_MASK: cpu_rdata = mask_q;
        ADDR_INT:  cpu_rdata = int_q;
        ADDR_CNTH: cpu_rdata = ecnt[FEBE_CNT_W-1 -: 8];
        ADDR_CNTL: cpu_rdata = snap_lo;
        default:   cpu_rdata = '0;
      endcase
    end
  end

  // R3
  ferf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ferf) || $fell(ferf)) |-> int_q[INT_FERF]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_int && aic_chg) |=> int_q[INT_AIC]);
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_int && int_set == '0) |=> (int_q == '0));
  // R8
  dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q & ~INT_LIVE) == '0);
endmodule

// File: tb/tb_ds3_rx_oh_monitor.sv
module tb_ds3_rx_oh_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oh_valid = 1'b0, oh_aic = 1'b0, oh_idle = 1'b0;
  logic [1:0] oh_xbits = 2'b11;
  logic [2:0] oh_febe = 3'b111;
  logic       oh_ready, irq;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ds3_rx_oh_monitor dut (
    .clk(clk), .rst_n(rst_n), .oh_valid(oh_valid), .oh_ready(oh_ready),
    .oh_xbits(oh_xbits), .oh_febe(oh_febe), .oh_aic(oh_aic), .oh_idle(oh_idle),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  // monitor: scoreboard compare of every read
  always @(negedge clk) begin
    if (cpu_rd) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (cpu_rdata !== e) begin
        n_fail++;
        $display("FAIL %s addr %h: got %h expected %h", t, cpu_addr, cpu_rdata, e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    cpu_rd = 1'b1; cpu_addr = a;
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic frames(input int n, input logic [1:0] x, input logic [2:0] fb,
                        input logic ac, input logic idl);
    @(posedge clk); #1;
    oh_valid = 1'b1; oh_xbits = x; oh_febe = fb; oh_aic = ac; oh_idle = idl;
    repeat (n) @(posedge clk);
    #1 oh_valid = 1'b0;
  endtask

  task automatic frame_rd(input logic [1:0] x, input logic [2:0] fb, input logic ac,
                          input logic [7:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    oh_valid = 1'b1; oh_xbits = x; oh_febe = fb; oh_aic = ac; oh_idle = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    cpu_rd = 1'b1; cpu_addr = a;
    @(posedge clk); #1;
    oh_valid = 1'b0; cpu_rd = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    chk(oh_ready, 1'b1, "R1 ready");
    rd(8'h11, 8'h00, "R1 stat");
    rd(8'h12, 8'h00, "R1 mask");
    rd(8'h13, 8'h00, "R1 int");
    rd(8'h58, 8'h00, "R1 cnt hi");
    rd(8'h59, 8'h00, "R1 cnt lo");
    // R9 mask register
    wr(8'h12, 8'hFF);
    rd(8'h12, 8'hFF, "R9 mask rw");
    // R2 R3 alarm entry
    frames(1, 2'b00, 3'b111, 1'b0, 1'b0);
    chk(irq, 1'b1, "R9 irq on flag");
    rd(8'h11, 8'h17, "R2 ferf set");
    rd(8'h13, 8'h08, "R3 ferf flag");
    rd(8'h13, 8'h00, "R8 clear on read");
    chk(irq, 1'b0, "R9 irq after clear");
    // R2 mixed X-bits hold
    frames(1, 2'b01, 3'b111, 1'b0, 1'b0);
    rd(8'h11, 8'h17, "R2 hold 01");
    frames(1, 2'b10, 3'b111, 1'b0, 1'b0);
    rd(8'h11, 8'h17, "R2 hold 10");
    rd(8'h13, 8'h00, "R3 no flag on hold");
    // R2 exit, R5 count
    frames(1, 2'b11, 3'b010, 1'b0, 1'b0);
    rd(8'h11, 8'h02, "R2 ferf clear R4 febe");
    rd(8'h13, 8'h08, "R3 flag on exit");
    // R4 AIC change
    frames(1, 2'b11, 3'b111, 1'b1, 1'b0);
    rd(8'h11, 8'h0F, "R4 aic state");
    rd(8'h13, 8'h04, "R4 aic flag");
    frames(1, 2'b11, 3'b000, 1'b1, 1'b0);
    frames(1, 2'b11, 3'b110, 1'b1, 1'b0);
    frames(1, 2'b11, 3'b011, 1'b1, 1'b0);
    frames(2, 2'b11, 3'b111, 1'b1, 1'b0);
    rd(8'h58, 8'h00, "R6 hi");
    rd(8'h59, 8'h04, "R5 R6 lo count");
    rd(8'h58, 8'h00, "R6 hi after clear");
    rd(8'h59, 8'h00, "R6 lo after clear");
    // R6 clear collides with an error frame
    frame_rd(2'b00, 3'b001, 1'b1, 8'h59, 8'h00, "R6 lo during inc");
    rd(8'h58, 8'h00, "R6 hi collide");
    rd(8'h59, 8'h01, "R6 inc kept");
    // R8 flag read collides with a new alarm change
    frame_rd(2'b11, 3'b111, 1'b1, 8'h13, 8'h08, "R8 read old flags");
    rd(8'h13, 8'h08, "R8 set wins");
    rd(8'h13, 8'h00, "R8 cleared");
    // R5 saturation
    frames(65540, 2'b11, 3'b000, 1'b1, 1'b0);
    rd(8'h11, 8'h08, "R4 febe 000");
    rd(8'h58, 8'hFF, "R5 sat hi");
    rd(8'h59, 8'hFF, "R5 sat lo");
    // R7 idle up/down
    frames(14, 2'b11, 3'b111, 1'b1, 1'b1);
    rd(8'h13, 8'h00, "R7 below thr");
    frames(1, 2'b11, 3'b111, 1'b1, 1'b1);
    rd(8'h13, 8'h10, "R7 idle declared");
    frames(5, 2'b11, 3'b111, 1'b1, 1'b1);
    frames(14, 2'b11, 3'b111, 1'b1, 1'b0);
    rd(8'h13, 8'h00, "R7 still idle");
    frames(1, 2'b11, 3'b111, 1'b1, 1'b0);
    rd(8'h13, 8'h10, "R7 idle cleared");
    // R10 invalid frames ignored
    @(posedge clk); #1;
    oh_xbits = 2'b00; oh_febe = 3'b000; oh_aic = 1'b0; oh_idle = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    rd(8'h11, 8'h0F, "R10 stat unchanged");
    rd(8'h13, 8'h00, "R10 no flag");
    rd(8'h58, 8'h00, "R10 cnt hi");
    rd(8'h59, 8'h00, "R10 cnt lo");
    // R9 masking
    wr(8'h12, 8'h04);
    frames(1, 2'b00, 3'b111, 1'b1, 1'b0);
    chk(irq, 1'b0, "R9 masked ferf");
    rd(8'h13, 8'h08, "R9 flag present");
    frames(1, 2'b00, 3'b111, 1'b0, 1'b0);
    chk(irq, 1'b1, "R9 enabled aic");
    rd(8'h13, 8'h04, "R9 aic flag");
    chk(irq, 1'b0, "R9 irq dropped");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule